// File: doc/BRIEF.md
# Sector Protection Pulse Sequencer

This block runs, from the host side, the repeated pulse-and-verify routine that locks individual sectors of a parallel flash device. Software first loads the sector base addresses into a small internal list, then pulses `start` together with the number of list entries to process. The block raises a digital enable that stands in for the elevated voltage on the device's reset pin. It waits a fixed settling time and writes a setup command. For every listed sector it then writes a protect command, waits out the pulse time and writes a verify command. It reads the sector status back and repeats the pulse until the device reports the sector locked or the pulse budget is spent.

When the list is finished, or a sector gives up, the block lowers the voltage enable and then writes the device's return-to-read command. After that it reports completion, a failure flag and the list position of the failing sector. All device traffic uses a simple request/acknowledge bus master port. The bus holds one transaction at a time, and the device may stretch each transaction for any number of cycles.

The two waits are given in microseconds and converted to cycle counts from a clock-frequency parameter, so the same block can be retargeted by changing `CLK_MHZ`.

Top module: `sector_protect_seq`

## Requirements
- R1: Out of reset, and whenever no routine is running, `busy`, `hvEnable`, `busReq`, `done` and `fail` are all low.
- R2: A `start` pulse in idle raises `hvEnable`. The first bus request follows no sooner than SETTLE_US × CLK_MHZ cycles later and is a single write of 60H to address 0.
- R3: Each protect write puts 60H on the bus. Its address is the listed sector address with bit 6 forced to 0, bit 1 forced to 1 and bit 0 forced to 0; the verify write and the status read use that same address.
- R4: After a protect write is acknowledged, at least PULSE_US × CLK_MHZ cycles pass before the verify write of 40H is requested. The verify write is followed by one read.
- R5: A read value of exactly 01H marks the sector locked, and the block moves to the next list entry in ascending index order. Any other value (00H included) repeats the protect pulse on the same sector.
- R6: When MAX_PULSES (default 25) pulses on one sector all read back as not locked, the routine fails: `fail` and `done` are set, `failIdx` holds that sector's list index, and no later sector is touched. A sector that locks on exactly its MAX_PULSES-th pulse succeeds.
- R7: At the end of every routine, `hvEnable` falls at least one cycle before a single write of F0H to address 0. `done` rises only after that write is acknowledged, and it stays high with `busy` low until the next `start`.
- R8: A sector count of 0 still performs the settle and the setup write, then goes straight to the closing sequence and finishes with `done` high and `fail` low.
- R9: A `start` pulse while `busy` is high has no effect on the running routine or its results.
- R10: While `busReq` is high and `busAck` is low, `busReq`, `busWrite`, `busAddr` and `busWData` keep their values.
- R11: Every setup, protect, verify and read transaction occurs with `hvEnable` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the sector address list |
| cfgIdx | input | IDX_W (3) | List entry written by `cfgWe` |
| cfgAddr | input | ADDR_W (20) | Sector base address written into the list |
| start | input | 1 | One-cycle pulse that launches a routine from idle |
| sectorCount | input | CNT_W (4) | Number of list entries to process, sampled with `start` |
| busReq | output | 1 | Bus transaction request, held until acknowledged |
| busWrite | output | 1 | 1 for a write, 0 for a read |
| busAddr | output | ADDR_W (20) | Transaction address |
| busWData | output | 8 | Write data (command byte) |
| busRData | input | 8 | Read data, valid in the acknowledge cycle |
| busAck | input | 1 | Device completes the current transaction |
| hvEnable | output | 1 | Enable for the elevated voltage on the device reset pin |
| busy | output | 1 | A routine is running |
| done | output | 1 | Last routine finished (sticky until next start) |
| fail | output | 1 | Last routine ended with a sector that would not lock |
| failIdx | output | IDX_W (3) | List index of the failing sector |

## Verification
Almost every internal error shows up as a wrong bus transaction, and it shows up in the cycle the error takes effect. A timer loaded short brings the verify write or the setup write early. A wrong address mux shows up on the first protect write. A wrong index step makes the next transaction go to an unexpected sector. The pulse counter is the slow case: an off-by-one limit only appears after a sector has used up its whole budget of pulses, which is up to 25 pulse waits after the sector started. The bench therefore uses a responder that locks sectors after 25, 26 or never-reached pulse counts, and counts the pulses each sector receives.

// File: rtl/spp_pkg.sv
package spp_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SETUP  = 3'd1,
    OP_LOCK   = 3'd2,
    OP_CHECK  = 3'd3,
    OP_STATUS = 3'd4,
    OP_EXIT   = 3'd5
  } busOp_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_SETUP,
    ST_LOCK,
    ST_PULSE,
    ST_CHECK,
    ST_STATUS,
    ST_DROP,
    ST_EXIT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   loadSettle;
    logic   loadPulse;
    logic   latchCount;
    logic   clrIdx;
    logic   incIdx;
    logic   firstPulse;
    logic   incPulse;
    logic   markFail;
    logic   finish;
    logic   clrResult;
    busOp_e op;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic timerZero;
    logic listEmpty;
    logic lastSector;
    logic pulseLimit;
    logic readOk;
  } dpStatus_t;

  localparam logic [7:0] CMD_LOCK   = 8'h60;
  localparam logic [7:0] CMD_CHECK  = 8'h40;
  localparam logic [7:0] CMD_EXIT   = 8'hF0;
  localparam logic [7:0] ANS_LOCKED = 8'h01;

endpackage

// File: rtl/spp_datapath.sv
module spp_datapath
  import spp_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int MAX_SECTORS = 8,
  parameter int MAX_PULSES  = 25,
  parameter int SETTLE_CYC  = 200,
  parameter int PULSE_CYC   = 7500,
  localparam int IDX_W  = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1,
  localparam int CNT_W  = $clog2(MAX_SECTORS + 1),
  localparam int PCNT_W = $clog2(MAX_PULSES + 1),
  localparam int TMAX   = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC,
  localparam int TMR_W  = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  output dpStatus_t         stat,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [CNT_W-1:0]  sectorCount,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWData,
  input  logic [7:0]        busRData,
  output logic              done,
  output logic              fail,
  output logic [IDX_W-1:0]  failIdx
);

  logic [ADDR_W-1:0] sectorMem [MAX_SECTORS];
  logic [TMR_W-1:0]  timer;
  logic [IDX_W-1:0]  sectorIdx;
  logic [CNT_W-1:0]  countReg;
  logic [PCNT_W-1:0] pulseCnt;
  logic              doneReg;
  logic              failReg;
  logic [IDX_W-1:0]  failIdxReg;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] lockAddr;

  // sector address list, one register per entry
  for (genvar g = 0; g < MAX_SECTORS; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sectorMem[g] <= '0;
      end else if (cfgWe && (cfgIdx == IDX_W'(g))) begin
        sectorMem[g] <= cfgAddr;
      end
    end
  end

  // shared wait timer, counts down to zero and holds
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strb.loadSettle) begin
      timer <= TMR_W'(SETTLE_CYC - 1);
    end else if (strb.loadPulse) begin
      timer <= TMR_W'(PULSE_CYC - 1);
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  // list walk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg  <= '0;
      sectorIdx <= '0;
    end else begin
      if (strb.latchCount) begin
        countReg <= (sectorCount > CNT_W'(MAX_SECTORS)) ? CNT_W'(MAX_SECTORS) : sectorCount;
      end
      if (strb.clrIdx) begin
        sectorIdx <= '0;
      end else if (strb.incIdx) begin
        sectorIdx <= sectorIdx + 1'b1;
      end
    end
  end

  // pulse counter for the current sector
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.firstPulse) begin
      pulseCnt <= PCNT_W'(1);
    end else if (strb.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // outcome registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneReg    <= 1'b0;
      failReg    <= 1'b0;
      failIdxReg <= '0;
    end else if (strb.clrResult) begin
      doneReg    <= 1'b0;
      failReg    <= 1'b0;
      failIdxReg <= '0;
    end else begin
      if (strb.markFail) begin
        failReg    <= 1'b1;
        failIdxReg <= sectorIdx;
      end
      if (strb.finish) begin
        doneReg <= 1'b1;
      end
    end
  end

  // address formatting: bit6=0, bit1=1, bit0=0
  always_comb begin
    curAddr     = sectorMem[sectorIdx];
    lockAddr    = curAddr;
    lockAddr[6] = 1'b0;
    lockAddr[1] = 1'b1;
    lockAddr[0] = 1'b0;
  end

  // bus transaction decode
  always_comb begin
    busReq   = 1'b1;
    busWrite = 1'b1;
    busAddr  = '0;
    busWData = '0;
    unique case (strb.op)
      OP_SETUP:  busWData = CMD_LOCK;
      OP_LOCK: begin
        busAddr  = lockAddr;
        busWData = CMD_LOCK;
      end
      OP_CHECK: begin
        busAddr  = lockAddr;
        busWData = CMD_CHECK;
      end
      OP_STATUS: begin
        busAddr  = lockAddr;
        busWrite = 1'b0;
      end
      OP_EXIT:   busWData = CMD_EXIT;
      default: begin
        busReq   = 1'b0;
        busWrite = 1'b0;
      end
    endcase
  end

  always_comb begin
    stat.timerZero  = (timer == '0);
    stat.listEmpty  = (countReg == '0);
    stat.lastSector = ((CNT_W'(sectorIdx) + CNT_W'(1)) == countReg);
    stat.pulseLimit = (pulseCnt >= PCNT_W'(MAX_PULSES));
    stat.readOk     = (busRData == ANS_LOCKED);
  end

  assign done    = doneReg;
  assign fail    = doneReg & failReg;
  assign failIdx = failIdxReg;

endmodule

// File: rtl/spp_control.sv
module spp_control
  import spp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        busAck,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        hvEnable,
  output logic        busy
);

  seqState_e state;
  seqState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.loadSettle = 1'b1;
          strb.latchCount = 1'b1;
          strb.clrResult  = 1'b1;
          nextState       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (stat.timerZero) nextState = ST_SETUP;
      end
      ST_SETUP: begin
        strb.op = OP_SETUP;
        if (busAck) begin
          strb.clrIdx     = 1'b1;
          strb.firstPulse = 1'b1;
          nextState       = stat.listEmpty ? ST_DROP : ST_LOCK;
        end
      end
      ST_LOCK: begin
        strb.op = OP_LOCK;
        if (busAck) begin
          strb.loadPulse = 1'b1;
          nextState      = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (stat.timerZero) nextState = ST_CHECK;
      end
      ST_CHECK: begin
        strb.op = OP_CHECK;
        if (busAck) nextState = ST_STATUS;
      end
      ST_STATUS: begin
        strb.op = OP_STATUS;
        if (busAck) begin
          if (stat.readOk) begin
            if (stat.lastSector) begin
              nextState = ST_DROP;
            end else begin
              strb.incIdx     = 1'b1;
              strb.firstPulse = 1'b1;
              nextState       = ST_LOCK;
            end
          end else if (stat.pulseLimit) begin
            strb.markFail = 1'b1;
            nextState     = ST_DROP;
          end else begin
            strb.incPulse = 1'b1;
            nextState     = ST_LOCK;
          end
        end
      end
      ST_DROP: nextState = ST_EXIT;
      ST_EXIT: begin
        strb.op = OP_EXIT;
        if (busAck) begin
          strb.finish = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign hvEnable = (state == ST_SETTLE) || (state == ST_SETUP) || (state == ST_LOCK) ||
                    (state == ST_PULSE)  || (state == ST_CHECK) || (state == ST_STATUS);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/sector_protect_seq.sv
module sector_protect_seq
  import spp_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int MAX_SECTORS = 8,
  parameter int MAX_PULSES  = 25,
  parameter int CLK_MHZ     = 50,
  parameter int SETTLE_US   = 4,
  parameter int PULSE_US    = 150,
  localparam int IDX_W      = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1,
  localparam int CNT_W      = $clog2(MAX_SECTORS + 1),
  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_US > 0) ? CLK_MHZ * SETTLE_US : 1,
  localparam int PULSE_CYC  = (CLK_MHZ * PULSE_US > 0) ? CLK_MHZ * PULSE_US : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              start,
  input  logic [CNT_W-1:0]  sectorCount,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWData,
  input  logic [7:0]        busRData,
  input  logic              busAck,
  output logic              hvEnable,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [IDX_W-1:0]  failIdx
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  spp_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .busAck   (busAck),
    .stat     (stat),
    .strb     (strb),
    .hvEnable (hvEnable),
    .busy     (busy)
  );

  spp_datapath #(
    .ADDR_W      (ADDR_W),
    .MAX_SECTORS (MAX_SECTORS),
    .MAX_PULSES  (MAX_PULSES),
    .SETTLE_CYC  (SETTLE_CYC),
    .PULSE_CYC   (PULSE_CYC)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .stat        (stat),
    .cfgWe       (cfgWe),
    .cfgIdx      (cfgIdx),
    .cfgAddr     (cfgAddr),
    .sectorCount (sectorCount),
    .busReq      (busReq),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .busWData    (busWData),
    .busRData    (busRData),
    .done        (done),
    .fail        (fail),
    .failIdx     (failIdx)
  );

endmodule

// File: rtl/sector_protect_seq_chk.sv
module sector_protect_seq_chk #(
  parameter int ADDR_W     = 20,
  parameter int SETTLE_CYC = 200,
  parameter int PULSE_CYC  = 7500,
  localparam int HW = $clog2(SETTLE_CYC + 1),
  localparam int GW = $clog2(PULSE_CYC + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [7:0]        busWData,
  input logic              busAck,
  input logic              hvEnable,
  input logic              busy,
  input logic              done
);

  logic [HW-1:0] hvCnt;
  logic [GW-1:0] gapCnt;

  // cycles since the voltage enable rose, saturating
  always_ff @(posedge clk) begin
    if (!rstN || !hvEnable) begin
      hvCnt <= '0;
    end else if (hvCnt != HW'(SETTLE_CYC)) begin
      hvCnt <= hvCnt + 1'b1;
    end
  end

  // cycles since the last acknowledged protect write, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (busReq && busAck && busWrite && busWData == 8'h60 && busAddr != '0) begin
      gapCnt <= '0;
    end else if (gapCnt != GW'(PULSE_CYC)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!busReq && !hvEnable));

  p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && hvEnable) |-> (hvCnt >= HW'(SETTLE_CYC)));

  p_check_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busWData == 8'h40) |-> (!busAddr[6] && busAddr[1] && !busAddr[0]));

  p_pulse_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busWData == 8'h40) |-> (gapCnt >= GW'(PULSE_CYC)));

  p_exit_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWrite && busWData == 8'hF0) |-> (!hvEnable && $past(!hvEnable)));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busWrite) && $stable(busAddr) && $stable(busWData)));

  p_hv_cmd_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && (!busWrite || busWData == 8'h60 || busWData == 8'h40)) |-> hvEnable);

endmodule

bind sector_protect_seq sector_protect_seq_chk #(
  .ADDR_W     (ADDR_W),
  .SETTLE_CYC (SETTLE_CYC),
  .PULSE_CYC  (PULSE_CYC)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busReq   (busReq),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWData (busWData),
  .busAck   (busAck),
  .hvEnable (hvEnable),
  .busy     (busy),
  .done     (done)
);

// File: tb/sim_sector_protect_seq.sv
`timescale 1ns/1ps
module sim_sector_protect_seq;

  localparam int CLK_MHZ     = 1;
  localparam int SETTLE_US   = 4;
  localparam int PULSE_US    = 150;
  localparam int MAX_PULSES  = 25;
  localparam int MAX_SECTORS = 8;
  localparam int ADDR_W      = 20;
  localparam int SETTLE_CYC  = CLK_MHZ * SETTLE_US;
  localparam int PULSE_CYC   = CLK_MHZ * PULSE_US;
  localparam int NEVER       = 31;

  typedef struct packed {
    logic [3:0] count;
    logic [4:0] n3;
    logic [4:0] n2;
    logic [4:0] n1;
    logic [4:0] n0;
    logic       expFail;
    logic [2:0] expIdx;
    logic [5:0] expPulses;
  } vec_t;

  // pulses each sector needs before it reads back locked
  localparam vec_t VEC [6] = '{
    '{4'd1, 5'd0, 5'd0, 5'd0,  5'd1,  1'b0, 3'd0, 6'd1},
    '{4'd3, 5'd0, 5'd2, 5'd3,  5'd1,  1'b0, 3'd0, 6'd6},
    '{4'd2, 5'd0, 5'd0, 5'd31, 5'd2,  1'b1, 3'd1, 6'd27},
    '{4'd4, 5'd1, 5'd1, 5'd1,  5'd25, 1'b0, 3'd0, 6'd28},
    '{4'd3, 5'd0, 5'd1, 5'd26, 5'd1,  1'b1, 3'd1, 6'd26},
    '{4'd1, 5'd0, 5'd0, 5'd0,  5'd31, 1'b1, 3'd0, 6'd25}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [2:0]        cfgIdx = '0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic              start = 1'b0;
  logic [3:0]        sectorCount = '0;
  logic              busReq;
  logic              busWrite;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0]        busWData;
  logic [7:0]        busRData = '0;
  logic              busAck = 1'b0;
  logic              hvEnable;
  logic              busy;
  logic              done;
  logic              fail;
  logic [2:0]        failIdx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // responder bookkeeping
  int need [8];
  int pulses [8];
  int setupCnt, exitCnt, seqErr, hvErr, gapErr, settleErr;
  int lastIdx, checkIdx, ackCyc, hvCyc;
  bit hvPrev = 1'b0;

  sector_protect_seq #(
    .ADDR_W      (ADDR_W),
    .MAX_SECTORS (MAX_SECTORS),
    .MAX_PULSES  (MAX_PULSES),
    .CLK_MHZ     (CLK_MHZ),
    .SETTLE_US   (SETTLE_US),
    .PULSE_US    (PULSE_US)
  ) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgAddr(cfgAddr),
    .start(start), .sectorCount(sectorCount), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWData(busWData), .busRData(busRData), .busAck(busAck),
    .hvEnable(hvEnable), .busy(busy), .done(done), .fail(fail), .failIdx(failIdx)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [ADDR_W-1:0] baseAddr(int i);
    return ADDR_W'(((i + 1) << 12) | 'h43);
  endfunction

  function automatic logic [ADDR_W-1:0] lockedForm(logic [ADDR_W-1:0] a);
    return (a & ~ADDR_W'('h43)) | ADDR_W'('h2);
  endfunction

  function automatic int findSector(logic [ADDR_W-1:0] a);
    for (int i = 0; i < 8; i++) begin
      if (lockedForm(baseAddr(i)) == a) return i;
    end
    return -1;
  endfunction

  // behavioural flash responder: one transaction every two cycles at most
  always @(negedge clk) begin
    int k;
    if (hvEnable && !hvPrev) hvCyc = cyc;
    hvPrev = hvEnable;
    if (busAck) begin
      busAck = 1'b0;
    end else if (busReq && rstN) begin
      busAck = 1'b1;
      k = findSector(busAddr);
      if (busWrite && busWData == 8'h60 && busAddr == '0) begin
        setupCnt++;
        if (!hvEnable || (cyc - hvCyc) < SETTLE_CYC) settleErr++;
      end else if (busWrite && busWData == 8'h60) begin
        if (k < 0 || k < lastIdx) seqErr++;
        else begin
          pulses[k]++;
          lastIdx = k;
        end
        if (!hvEnable) hvErr++;
        checkIdx = -1;
        ackCyc = cyc;
      end else if (busWrite && busWData == 8'h40) begin
        if (k != lastIdx) seqErr++;
        if ((cyc - ackCyc) < PULSE_CYC + 1) gapErr++;
        if (!hvEnable) hvErr++;
        checkIdx = k;
      end else if (!busWrite) begin
        if (k < 0 || k != checkIdx) seqErr++;
        busRData = (k >= 0 && pulses[k] >= need[k]) ? 8'h01 : 8'h00;
        checkIdx = -1;
      end else if (busWData == 8'hF0 && busAddr == '0) begin
        exitCnt++;
        if (hvEnable) hvErr++;
      end else begin
        seqErr++;
      end
    end
  end

  task automatic checkEq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearResponder();
    for (int i = 0; i < 8; i++) pulses[i] = 0;
    setupCnt = 0; exitCnt = 0; seqErr = 0; hvErr = 0; gapErr = 0; settleErr = 0;
    lastIdx = 0; checkIdx = -1; ackCyc = 0;
  endtask

  task automatic loadList(int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgIdx = 3'(i); cfgAddr = baseAddr(i);
    end
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic launch(int count);
    @(negedge clk);
    sectorCount = 4'(count); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!done) checkEq("R7 routine completes", 0, 1);
  endtask

  task automatic commonEnd();
    checkEq("R7 done after exit write", int'(done), 1);
    checkEq("R7 busy low at end", int'(busy), 0);
    checkEq("R7 hv low at end", int'(hvEnable), 0);
    checkEq("R7 exit writes", exitCnt, 1);
    checkEq("R2 setup writes", setupCnt, 1);
    checkEq("R2 settle respected", settleErr, 0);
    checkEq("R3 R5 address and order", seqErr, 0);
    checkEq("R4 pulse wait", gapErr, 0);
    checkEq("R11 hv during commands", hvErr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearResponder();
    for (int i = 0; i < 8; i++) need[i] = 1;
    repeat (4) @(negedge clk);
    // R1: reset state
    checkEq("R1 busy in reset", int'(busy), 0);
    checkEq("R1 hv in reset", int'(hvEnable), 0);
    checkEq("R1 req in reset", int'(busReq), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 idle busy", int'(busy), 0);
    checkEq("R1 idle done", int'(done), 0);
    checkEq("R1 idle fail", int'(fail), 0);
    checkEq("R1 idle req", int'(busReq), 0);

    // vector walk: R5 and R6 over several lock profiles
    for (int v = 0; v < 6; v++) begin
      int alive;
      int total;
      int cnt;
      cnt = int'(VEC[v].count);
      need[0] = int'(VEC[v].n0); need[1] = int'(VEC[v].n1);
      need[2] = int'(VEC[v].n2); need[3] = int'(VEC[v].n3);
      clearResponder();
      loadList(cnt);
      launch(cnt);
      checkEq("R2 hv raised by start", int'(hvEnable), 1);
      waitDone();
      commonEnd();
      checkEq("R6 fail flag", int'(fail), int'(VEC[v].expFail));
      if (VEC[v].expFail) checkEq("R6 fail index", int'(failIdx), int'(VEC[v].expIdx));
      alive = 1;
      total = 0;
      for (int i = 0; i < cnt; i++) begin
        int e;
        e = 0;
        if (alive != 0) begin
          e = (need[i] <= MAX_PULSES) ? need[i] : MAX_PULSES;
          if (need[i] > MAX_PULSES) alive = 0;
        end
        checkEq("R5 R6 pulses on sector", pulses[i], e);
        total += pulses[i];
      end
      checkEq("R6 total pulses", total, int'(VEC[v].expPulses));
    end

    // R8: empty list
    clearResponder();
    launch(0);
    waitDone();
    commonEnd();
    checkEq("R8 no fail on empty list", int'(fail), 0);
    checkEq("R8 no protect pulses", pulses[0], 0);

    // R9: start while running is ignored
    clearResponder();
    need[0] = 3; need[1] = 1; need[2] = 1;
    loadList(2);
    launch(2);
    repeat (200) @(negedge clk);
    checkEq("R9 busy mid run", int'(busy), 1);
    checkEq("R7 done low mid run", int'(done), 0);
    launch(3);
    waitDone();
    commonEnd();
    checkEq("R9 sector0 pulses", pulses[0], 3);
    checkEq("R9 sector1 pulses", pulses[1], 1);
    checkEq("R9 sector2 untouched", pulses[2], 0);
    checkEq("R9 no fail", int'(fail), 0);

    // R7: done is sticky while idle
    repeat (20) @(negedge clk);
    checkEq("R7 done held", int'(done), 1);
    checkEq("R1 idle req after run", int'(busReq), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule